// File: doc/BRIEF.md
# NAND ECC Geometry Calculator

This block works out the error-correction layout of a NAND page from two numbers the device reports: the size of the data area and the size of the spare area, both in bytes. It picks the chunk size and Galois field order and counts the chunks per page. It sets the per-chunk correction strength and finds where the factory bad-block marker lands once data chunks and parity are interleaved. That last result is a byte offset plus a bit offset in the data view the ECC engine presents.

A caller drives the sizes and a strength-limit select, then pulses `start`. The block takes the inputs on that edge and runs two divisions through one shared restoring divider. It then pulses `done` for one cycle. All results hold from the `done` cycle until the next accepted start. An unsupported spare size, or a page smaller than one chunk, sets `err`.

Top module: `nand_ecc_geom`

## Requirements
- R1: When the spare size is above 512 bytes, `fieldOrder` is 14 and `chunkBytes` is 1024. Otherwise `fieldOrder` is 13 and `chunkBytes` is 512.
- R2: `err` is 1 when the spare size is greater than `chunkBytes`, or when the page is smaller than one chunk (chunk count 0). Otherwise it is 0.
- R3: `chunkCount` is the page data size divided by `chunkBytes`, rounded down.
- R4: The raw strength is (spare − 10) × 8 divided by (`fieldOrder` × `chunkCount`), rounded down. The 10 bytes are metadata, and a spare size below 10 gives 0.
- R5: `strength` is the raw strength rounded down to an even number and then limited to 40. When `extCap` is 1 the limit is 62 instead.
- R6: Let B = page × 8 − 80 and T = `chunkBytes` × 8 + `strength` × `fieldOrder`. Divide B by T to get chunk index I and remainder M. If M > `chunkBytes` × 8, the marker position is 1. Otherwise it is B − I × `strength` × `fieldOrder`.
- R7: `markByte` is the marker position shifted right by 3, and `markBit` is its low 3 bits.
- R8: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after the accepted start until `done` rises, and is low while `done` is high. All result outputs hold their values until the next accepted start.
- R9: A `start` while `busy` is high has no effect: the results that follow match the inputs taken at the first start.
- R10: After reset, `busy`, `done`, `err` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Take the inputs and begin a calculation |
| pageBytes | input | PAGE_W | Page data size in bytes |
| spareBytes | input | SPARE_W | Spare area size in bytes |
| extCap | input | 1 | Select the strength limit of 62 instead of 40 |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported geometry |
| chunkBytes | output | 11 | Data bytes per ECC chunk |
| fieldOrder | output | 4 | Galois field order |
| chunkCount | output | PAGE_W | Chunks per page |
| strength | output | 6 | Correctable bits per chunk |
| markByte | output | PAGE_W | Byte offset of the bad-block marker |
| markBit | output | 3 | Bit offset of the bad-block marker within that byte |

## Verification
`busy` is due one cycle after the start edge. Every result is due together in the single cycle in which `done` is high. That cycle follows two full divider passes plus a few control cycles. The bench does not assume a fixed count. It polls `done` at falling edges under a per-operation bound and compares all results in that same cycle. It checks in the next cycle that `done` has dropped and that the results have not moved. This holds even when a second `start` arrives mid-calculation.

// File: rtl/nand_ecc_geom_pkg.sv
package nand_ecc_geom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PREP1, S_RUN1, S_PREP2, S_RUN2, S_FIN
  } geomState_t;

  typedef struct packed {
    logic latch;        // take inputs
    logic divGo;        // launch divider
    logic selSecond;    // operands of the marker division
    logic capStrength;  // store strength from first quotient
    logic capResult;    // publish all outputs
  } geomStrobes_t;
endpackage

// File: rtl/geom_divider.sv
module geom_divider #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         fin
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       remR;
  logic [W-1:0]     quoR;
  logic [W-1:0]     denR;
  logic [CNT_W-1:0] cnt;
  logic             finR;
  logic [W:0]       shifted;
  logic             fits;

  assign shifted = {remR[W-1:0], quoR[W-1]};
  assign fits    = shifted >= {1'b0, denR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      denR <= '0;
      cnt  <= '0;
      finR <= 1'b0;
    end else begin
      finR <= 1'b0;
      if (go) begin
        remR <= '0;
        quoR <= num;
        denR <= den;
        cnt  <= CNT_W'(W);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (fits) begin
          remR <= shifted - {1'b0, denR};
          quoR <= {quoR[W-2:0], 1'b1};
        end else begin
          remR <= shifted;
          quoR <= {quoR[W-2:0], 1'b0};
        end
        if (cnt == CNT_W'(1)) finR <= 1'b1;
      end
    end
  end

  assign quo = quoR;
  assign rem = remR[W-1:0];
  assign fin = finR;

  // R6
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rstN)
    fin && (denR != '0) |-> (rem < denR));
  // R8
  fin_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fin |=> !fin);
endmodule

// File: rtl/geom_datapath.sv
module geom_datapath
  import nand_ecc_geom_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int SPARE_W    = 11,
  parameter int META_BYTES = 10,
  parameter int CAP_STD    = 40,
  parameter int CAP_EXT    = 62
) (
  input  logic               clk,
  input  logic               rstN,
  input  geomStrobes_t       ctl,
  input  logic [PAGE_W-1:0]  pageBytes,
  input  logic [SPARE_W-1:0] spareBytes,
  input  logic               extCap,
  output logic               errNow,
  output logic               divFin,
  output logic               err,
  output logic [10:0]        chunkBytes,
  output logic [3:0]         fieldOrder,
  output logic [PAGE_W-1:0]  chunkCount,
  output logic [5:0]         strength,
  output logic [PAGE_W-1:0]  markByte,
  output logic [2:0]         markBit
);
  localparam int DIV_W   = PAGE_W + 3;
  localparam int SMALL_C = 512;
  localparam int LARGE_C = 1024;

  logic [PAGE_W-1:0]  pageR;
  logic [SPARE_W-1:0] spareR;
  logic               extR;
  logic [5:0]         strR;

  logic               bigSpare;
  logic [3:0]         gfC;
  logic [10:0]        chunkC;
  logic [PAGE_W-1:0]  cntC;
  logic [DIV_W-1:0]   num1, den1, markBits, eccBits, chunkBits;
  logic [DIV_W-1:0]   divNum, divDen, quo, rem, evenQ, capQ, posC;

  assign bigSpare = spareR > SPARE_W'(SMALL_C);
  assign gfC      = bigSpare ? 4'd14 : 4'd13;
  assign chunkC   = bigSpare ? 11'(LARGE_C) : 11'(SMALL_C);
  assign cntC     = bigSpare ? (pageR >> 10) : (pageR >> 9);
  assign errNow   = (DIV_W'(spareR) > DIV_W'(chunkC)) || (cntC == '0);

  assign num1      = (spareR >= SPARE_W'(META_BYTES))
                     ? DIV_W'(spareR - SPARE_W'(META_BYTES)) << 3 : '0;
  assign den1      = DIV_W'(gfC) * DIV_W'(cntC);
  assign markBits  = (DIV_W'(pageR) << 3) - DIV_W'(META_BYTES * 8);
  assign eccBits   = DIV_W'(strR) * DIV_W'(gfC);
  assign chunkBits = (DIV_W'(chunkC) << 3) + eccBits;

  assign divNum = ctl.selSecond ? markBits  : num1;
  assign divDen = ctl.selSecond ? chunkBits : den1;

  geom_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .go(ctl.divGo), .num(divNum), .den(divDen),
    .quo(quo), .rem(rem), .fin(divFin)
  );

  assign evenQ = {quo[DIV_W-1:1], 1'b0};
  assign capQ  = extR ? DIV_W'(CAP_EXT) : DIV_W'(CAP_STD);
  assign posC  = (rem > (DIV_W'(chunkC) << 3)) ? DIV_W'(1)
                                               : markBits - quo * eccBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageR <= '0; spareR <= '0; extR <= 1'b0; strR <= '0;
      err <= 1'b0; chunkBytes <= '0; fieldOrder <= '0; chunkCount <= '0;
      strength <= '0; markByte <= '0; markBit <= '0;
    end else begin
      if (ctl.latch) begin
        pageR  <= pageBytes;
        spareR <= spareBytes;
        extR   <= extCap;
        strR   <= '0;
      end
      if (ctl.capStrength)
        strR <= (evenQ < capQ) ? 6'(evenQ) : 6'(capQ);
      if (ctl.capResult) begin
        err        <= errNow;
        chunkBytes <= chunkC;
        fieldOrder <= gfC;
        chunkCount <= cntC;
        strength   <= errNow ? '0 : strR;
        markByte   <= errNow ? '0 : PAGE_W'(posC >> 3);
        markBit    <= errNow ? '0 : posC[2:0];
      end
    end
  end

  // R5
  strength_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capResult |=> (strength[0] == 1'b0) && (strength <= 6'(CAP_EXT)));
  // R1
  field_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fieldOrder == 4'd14) |-> (chunkBytes == 11'(LARGE_C)));
endmodule

// File: rtl/geom_control.sv
module geom_control
  import nand_ecc_geom_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         errNow,
  input  logic         divFin,
  output geomStrobes_t ctl,
  output logic         busy,
  output logic         done
);
  geomState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      S_IDLE:  if (start) begin ctl.latch = 1'b1; nextState = S_PREP1; end
      S_PREP1: if (errNow) nextState = S_FIN;
               else begin ctl.divGo = 1'b1; nextState = S_RUN1; end
      S_RUN1:  if (divFin) begin ctl.capStrength = 1'b1; nextState = S_PREP2; end
      S_PREP2: begin ctl.divGo = 1'b1; ctl.selSecond = 1'b1; nextState = S_RUN2; end
      S_RUN2:  begin ctl.selSecond = 1'b1; if (divFin) nextState = S_FIN; end
      S_FIN:   begin ctl.selSecond = 1'b1; ctl.capResult = 1'b1; nextState = S_IDLE; end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == S_FIN);
    end
  end

  assign busy = (state != S_IDLE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done && start && (state != S_FIN) |=> busy);
endmodule

// File: rtl/nand_ecc_geom.sv
module nand_ecc_geom
  import nand_ecc_geom_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int SPARE_W    = 11,
  parameter int META_BYTES = 10,
  parameter int CAP_STD    = 40,
  parameter int CAP_EXT    = 62
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PAGE_W-1:0]  pageBytes,
  input  logic [SPARE_W-1:0] spareBytes,
  input  logic               extCap,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [10:0]        chunkBytes,
  output logic [3:0]         fieldOrder,
  output logic [PAGE_W-1:0]  chunkCount,
  output logic [5:0]         strength,
  output logic [PAGE_W-1:0]  markByte,
  output logic [2:0]         markBit
);
  geomStrobes_t ctl;
  logic         errNow, divFin;

  geom_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .errNow(errNow), .divFin(divFin),
    .ctl(ctl), .busy(busy), .done(done)
  );

  geom_datapath #(
    .PAGE_W(PAGE_W), .SPARE_W(SPARE_W), .META_BYTES(META_BYTES),
    .CAP_STD(CAP_STD), .CAP_EXT(CAP_EXT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pageBytes(pageBytes),
    .spareBytes(spareBytes), .extCap(extCap), .errNow(errNow), .divFin(divFin),
    .err(err), .chunkBytes(chunkBytes), .fieldOrder(fieldOrder),
    .chunkCount(chunkCount), .strength(strength), .markByte(markByte),
    .markBit(markBit)
  );
endmodule

// File: tb/nand_ecc_geom_bench.sv
module nand_ecc_geom_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pageBytes = '0;
  logic [10:0] spareBytes = '0;
  logic        extCap = 1'b0;
  logic        busy, done, err;
  logic [10:0] chunkBytes;
  logic [3:0]  fieldOrder;
  logic [15:0] chunkCount, markByte;
  logic [5:0]  strength;
  logic [2:0]  markBit;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nand_ecc_geom u_nand_ecc_geom (
    .clk(clk), .rstN(rstN), .start(start), .pageBytes(pageBytes),
    .spareBytes(spareBytes), .extCap(extCap), .busy(busy), .done(done),
    .err(err), .chunkBytes(chunkBytes), .fieldOrder(fieldOrder),
    .chunkCount(chunkCount), .strength(strength), .markByte(markByte),
    .markBit(markBit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int page, input int spare, input bit ext,
                       output int gf, output int cb, output int cnt,
                       output bit e, output int s, output int pos);
    int raw, bits, total, idx, rm;
    gf  = (spare > 512) ? 14 : 13;
    cb  = (spare > 512) ? 1024 : 512;
    cnt = page / cb;
    e   = (spare > cb) || (cnt == 0);
    s = 0; pos = 0;
    if (!e) begin
      raw = ((spare >= 10) ? (spare - 10) * 8 : 0) / (gf * cnt);
      s = raw & ~1;
      if (s > (ext ? 62 : 40)) s = ext ? 62 : 40;
      bits  = page * 8 - 80;
      total = cb * 8 + s * gf;
      idx   = bits / total;
      rm    = bits - idx * total;
      pos   = (rm > cb * 8) ? 1 : bits - idx * s * gf;
    end
  endtask

  task automatic run(input int page, input int spare, input bit ext,
                     input bit poke);
    int gf, cb, cnt, s, pos, waitCnt;
    bit e;
    model(page, spare, ext, gf, cb, cnt, e, s, pos);
    @(negedge clk);
    pageBytes = 16'(page); spareBytes = 11'(spare); extCap = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", int'(busy), 1);
    pageBytes = 16'(page ^ 16'h5a5a); spareBytes = 11'(spare ^ 11'h2a5);
    extCap = ~ext;
    if (poke) begin
      start = 1'b1;  // R9: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) begin
      chk("R8 done timeout", 0, 1);
      return;
    end
    chk("R8 busy low with done", int'(busy), 0);
    chk("R1 fieldOrder", int'(fieldOrder), gf);
    chk("R1 chunkBytes", int'(chunkBytes), cb);
    chk("R2 err", int'(err), int'(e));
    chk("R3 chunkCount", int'(chunkCount), cnt);
    if (!e) begin
      chk(poke ? "R9 R5 strength" : "R4 R5 strength", int'(strength), s);
      chk("R6 R7 markByte", int'(markByte), pos >> 3);
      chk("R6 R7 markBit", int'(markBit), pos & 7);
    end
    @(negedge clk);
    chk("R8 done single", int'(done), 0);
    chk("R8 hold strength", int'(strength), e ? 0 : s);
    chk("R8 hold markByte", int'(markByte), e ? 0 : (pos >> 3));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 strength", int'(strength), 0);
    chk("R10 markByte", int'(markByte), 0);
    rstN = 1'b1;
    // directed corners
    run(2048, 64, 0, 0);
    run(4096, 224, 0, 0);
    run(512, 512, 0, 0);     // R5 cap 40
    run(512, 512, 1, 0);     // R5 cap 62
    run(8192, 1024, 0, 0);   // R1 large field, boundary accepted
    run(8192, 1025, 0, 0);   // R2 too large
    run(4096, 513, 1, 0);    // R1 switch point
    run(256, 64, 0, 0);      // R2 chunk count zero
    run(2048, 5, 0, 0);      // R4 spare below metadata
    run(2048, 64, 1, 1);     // R9 restart ignored
    for (int i = 0; i < 150; i++) begin
      int pg, sp;
      pg = ((1 + int'($urandom % 32)) * 512) + ((i % 4 == 0) ? int'($urandom % 512) : 0);
      sp = int'($urandom % 1100);
      run(pg, sp, 1'($urandom % 2), (i % 7 == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule